// File: doc/BRIEF.md
# Dual-Style Parallel Port Engine with DMA Handshake

This block sits between a synchronous FIFO and an 18-bit external parallel bus. In the processor role, an outside master drives the strobes. The block then turns the master's strobe activity into single-cycle push and pop pulses for the FIFO. The strobe pair is read either as a separate read strobe and write strobe (Intel style) or as a data strobe plus a read/write line (Motorola style). All external control inputs pass through a two-flop synchroniser and are then edge-detected on the system clock. No FIFO storage lives inside the block.

In the peripheral role, the block drives the strobe pins itself and runs a request/acknowledge DMA handshake that is paced by a separate port clock. The request input and the acknowledge output each have a selectable active level. Each acknowledged word lasts exactly one port-clock period. The block holds back the acknowledge while the FIFO cannot serve the transfer. The data bus output enable is raised only while a read access is in progress.

Top module: `dual_style_port`

## Requirements
- R1: With all configuration inputs low (Intel style, processor role), after reset: no push or pop occurs, bus_oe and strb_oe are low, the acknowledge stays inactive, and bus_d_o is zero.
- R2: Intel processor mode: strb_b_i is an active-low write strobe. Each low-to-high transition gives exactly one fifo_push pulse carrying the bus_d_i value present at that transition. The pulse starts after the second rising clock edge that samples the new strobe level and lasts one cycle.
- R3: Intel processor mode: strb_a_i is an active-low read strobe. Each high-to-low transition gives one fifo_pop pulse with the same latency. bus_d_o shows the popped word from the cycle after the pulse and holds it until the next pop.
- R4: Motorola processor mode (cfg_style_moto=1): strb_a_i is an active-low data strobe and strb_b_i is the read/write line (1 = read). A falling data strobe with the line high pops. A rising data strobe with the line low pushes. Push and pop never occur in the same cycle.
- R5: Peripheral mode (cfg_periph=1): strb_oe is high. On each synchronised rising edge of pclk_i, if the acknowledge is inactive, the request is active and the FIFO can serve the direction cfg_dir_rd (1 = FIFO to bus), then the acknowledge is raised and exactly one push or pop pulse occurs in that same cycle.
- R6: Once raised, the acknowledge stays active until the next synchronised pclk_i rising edge and then drops for at least one port-clock period.
- R7: A pop never occurs while fifo_empty is high and a push never occurs while fifo_full is high. In the processor role such a strobe edge is ignored. In the peripheral role the acknowledge is withheld.
- R8: The request is active when req_i equals cfg_req_pol. ack_o equals cfg_ack_pol while the acknowledge is active and its inverse otherwise.
- R9: Peripheral strobe outputs: in Intel style, strb_a_o is low during a read acknowledge, strb_b_o is low during a write acknowledge, and both are high otherwise. In Motorola style, strb_a_o is low during any acknowledge and strb_b_o equals cfg_dir_rd.
- R10: bus_oe is high only during a read access. In the processor role this means the synchronised read strobe is low (Intel) or the data strobe is low with the line high (Motorola). In the peripheral role it means a read-direction acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_style_moto | input | 1 | 0 = Intel strobe pair, 1 = Motorola strobe pair |
| cfg_periph | input | 1 | 0 = processor role, 1 = peripheral role |
| cfg_dir_rd | input | 1 | Peripheral transfer direction, 1 = FIFO to bus |
| cfg_req_pol | input | 1 | Active level of req_i |
| cfg_ack_pol | input | 1 | Active level of ack_o |
| strb_a_i | input | 1 | Read strobe (Intel) or data strobe (Motorola), processor role |
| strb_b_i | input | 1 | Write strobe (Intel) or read/write line (Motorola), processor role |
| strb_a_o | output | 1 | Strobe A driven in peripheral role |
| strb_b_o | output | 1 | Strobe B driven in peripheral role |
| strb_oe | output | 1 | Output enable for the strobe pins |
| req_i | input | 1 | DMA request |
| ack_o | output | 1 | DMA acknowledge |
| pclk_i | input | 1 | Port clock that paces the acknowledge |
| bus_d_i | input | 18 | Data bus input |
| bus_d_o | output | 18 | Data bus output |
| bus_oe | output | 1 | Data bus output enable |
| fifo_rd_data | input | 18 | Head word of the FIFO |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_full | input | 1 | FIFO full flag |
| fifo_push | output | 1 | Push pulse to the FIFO |
| fifo_pop | output | 1 | Pop pulse to the FIFO |
| fifo_wr_data | output | 18 | Word to be pushed |

## Verification
The assertions assume that the FIFO flags come from a real FIFO that is updated on the same clock. They also assume that configuration inputs change only while the bus is idle: strobes high, Motorola read/write line high, and no acknowledge pending. The assumption covers the data bus as well: it must stay stable for at least two clock cycles around a write strobe transition and while a peripheral request is held. The stimulus changes the configuration only after several idle cycles, parks the read/write line high before it leaves Motorola style, and updates write data only while the strobe is idle or a port-clock phase is low.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  typedef enum logic {
    STYLE_INTEL = 1'b0,
    STYLE_MOTO  = 1'b1
  } bus_style_e;

  // Positions of the control lines in the synchroniser vector.
  localparam int unsigned CTL_PCLK = 0;
  localparam int unsigned CTL_REQ  = 1;
  localparam int unsigned CTL_SB   = 2;
  localparam int unsigned CTL_SA   = 3;
  localparam int unsigned CTL_W    = 4;

  // Idle levels: strobes high, request and port clock low.
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1100;

  function automatic logic f_rise(input logic prev, input logic cur);
    return cur & ~prev;
  endfunction

  function automatic logic f_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  function automatic logic f_active(input logic level, input logic pol);
    return ~(level ^ pol);
  endfunction

  function automatic logic f_drive(input logic act, input logic pol);
    return act ? pol : ~pol;
  endfunction

endpackage

// File: rtl/dsp_sync.sv
module dsp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {N{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(N); i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[N-1];
endmodule

// File: rtl/dsp_edge.sv
module dsp_edge #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  import dsp_pkg::*;

  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < int'(W); i++) begin : g_bit
    assign rise[i] = f_rise(prev[i], lvl[i]);
    assign fall[i] = f_fall(prev[i], lvl[i]);
  end
endmodule

// File: rtl/dsp_proc_decode.sv
module dsp_proc_decode (
  input  logic style_moto,
  input  logic a_lvl,
  input  logic a_rise,
  input  logic a_fall,
  input  logic b_lvl,
  input  logic b_rise,
  output logic pop_ev,
  output logic push_ev,
  output logic rd_access
);
  import dsp_pkg::*;

  bus_style_e style;
  assign style = bus_style_e'(style_moto);

  always_comb begin
    pop_ev    = 1'b0;
    push_ev   = 1'b0;
    rd_access = 1'b0;
    unique case (style)
      STYLE_INTEL: begin
        // Separate active-low strobes: A reads, B writes.
        pop_ev    = a_fall;
        push_ev   = b_rise;
        rd_access = ~a_lvl;
      end
      STYLE_MOTO: begin
        // A is the data strobe, B the read/write line (high = read).
        pop_ev    = a_fall & b_lvl;
        push_ev   = a_rise & ~b_lvl;
        rd_access = ~a_lvl & b_lvl;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dsp_dma_hs.sv
module dsp_dma_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic req_act,
  input  logic ready,
  output logic ack_act,
  output logic xfer
);
  logic ack_q;

  // A word moves on the port-clock edge that raises the acknowledge.
  assign xfer = en & tick & ~ack_q & req_act & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
    end else if (!en) begin
      ack_q <= 1'b0;
    end else if (tick) begin
      ack_q <= xfer;
    end
  end

  assign ack_act = ack_q;
endmodule

// File: rtl/dual_style_port.sv
module dual_style_port #(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_style_moto,
  input  logic              cfg_periph,
  input  logic              cfg_dir_rd,
  input  logic              cfg_req_pol,
  input  logic              cfg_ack_pol,
  input  logic              strb_a_i,
  input  logic              strb_b_i,
  output logic              strb_a_o,
  output logic              strb_b_o,
  output logic              strb_oe,
  input  logic              req_i,
  output logic              ack_o,
  input  logic              pclk_i,
  input  logic [DATA_W-1:0] bus_d_i,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  output logic              fifo_push,
  output logic              fifo_pop,
  output logic [DATA_W-1:0] fifo_wr_data
);
  import dsp_pkg::*;

  // Synchronised control lines and data.
  logic [CTL_W-1:0]  ctl_raw, ctl_s, ctl_rise, ctl_fall;
  logic [DATA_W-1:0] dat_s;

  assign ctl_raw[CTL_SA]   = strb_a_i;
  assign ctl_raw[CTL_SB]   = strb_b_i;
  assign ctl_raw[CTL_REQ]  = req_i;
  assign ctl_raw[CTL_PCLK] = pclk_i;

  dsp_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  dsp_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d(bus_d_i), .q(dat_s)
  );

  dsp_edge #(.W(CTL_W), .RST_VAL(CTL_IDLE)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ctl_s), .rise(ctl_rise), .fall(ctl_fall)
  );

  // Processor-role decode.
  logic pop_ev, push_ev, proc_rd;

  dsp_proc_decode u_dec (
    .style_moto(cfg_style_moto),
    .a_lvl(ctl_s[CTL_SA]),
    .a_rise(ctl_rise[CTL_SA]),
    .a_fall(ctl_fall[CTL_SA]),
    .b_lvl(ctl_s[CTL_SB]),
    .b_rise(ctl_rise[CTL_SB]),
    .pop_ev(pop_ev),
    .push_ev(push_ev),
    .rd_access(proc_rd)
  );

  // Peripheral-role handshake; events named for the checker.
  logic pclk_tick, req_act, hs_ready, ack_act, hs_xfer;

  assign pclk_tick = ctl_rise[CTL_PCLK];
  assign req_act   = f_active(ctl_s[CTL_REQ], cfg_req_pol);
  assign hs_ready  = cfg_dir_rd ? ~fifo_empty : ~fifo_full;

  dsp_dma_hs u_hs (
    .clk(clk), .rst_n(rst_n), .en(cfg_periph), .tick(pclk_tick),
    .req_act(req_act), .ready(hs_ready), .ack_act(ack_act), .xfer(hs_xfer)
  );

  // FIFO side.
  logic proc_push, proc_pop;
  assign proc_push = push_ev & ~fifo_full;
  assign proc_pop  = pop_ev & ~fifo_empty;

  assign fifo_push    = cfg_periph ? (hs_xfer & ~cfg_dir_rd) : proc_push;
  assign fifo_pop     = cfg_periph ? (hs_xfer &  cfg_dir_rd) : proc_pop;
  assign fifo_wr_data = dat_s;

  logic [DATA_W-1:0] dout_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dout_q <= '0;
    else if (fifo_pop) dout_q <= fifo_rd_data;
  end
  assign bus_d_o = dout_q;

  assign bus_oe = cfg_periph ? (ack_act & cfg_dir_rd) : proc_rd;

  // Strobe pins in the peripheral role.
  always_comb begin
    if (bus_style_e'(cfg_style_moto) == STYLE_MOTO) begin
      strb_a_o = ~ack_act;
      strb_b_o = cfg_dir_rd;
    end else begin
      strb_a_o = ~(ack_act & cfg_dir_rd);
      strb_b_o = ~(ack_act & ~cfg_dir_rd);
    end
  end

  assign strb_oe = cfg_periph;
  assign ack_o   = f_drive(ack_act, cfg_ack_pol);

endmodule

// File: rtl/dual_style_port_chk.sv
module dual_style_port_chk #(
  parameter int unsigned DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_periph,
  input logic              cfg_dir_rd,
  input logic              fifo_empty,
  input logic              fifo_full,
  input logic              fifo_push,
  input logic              fifo_pop,
  input logic [DATA_W-1:0] bus_d_o,
  input logic              bus_oe,
  input logic              ack_act,
  input logic              pclk_tick
);

  p_idle_no_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_periph && $past(!cfg_periph)) |-> !ack_act);

  p_push_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |=> !fifo_push);

  p_pop_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);

  p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_pop |=> $stable(bus_d_o));

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_push && fifo_pop));

  p_ack_with_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_act) |-> $past(fifo_push || fifo_pop));

  p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_act && pclk_tick) |=> !ack_act);

  p_ack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_act && !pclk_tick && cfg_periph) |=> ack_act);

  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full);

  p_oe_needs_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_periph && $rose(bus_oe)) |-> ($rose(ack_act) && cfg_dir_rd));

endmodule

bind dual_style_port dual_style_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_periph(cfg_periph), .cfg_dir_rd(cfg_dir_rd),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_push(fifo_push),
  .fifo_pop(fifo_pop), .bus_d_o(bus_d_o), .bus_oe(bus_oe),
  .ack_act(ack_act), .pclk_tick(pclk_tick)
);

// File: tb/dual_style_port_bench.sv
module dual_style_port_bench;
  localparam int DW    = 18;
  localparam int QMAX  = 4;
  localparam int WDOG  = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_style_moto = 0, cfg_periph = 0, cfg_dir_rd = 0, cfg_req_pol = 1, cfg_ack_pol = 1;
  logic strb_a_i = 1, strb_b_i = 1, req_i = 0, pclk_i = 0;
  logic [DW-1:0] bus_d_i = '0;
  logic [DW-1:0] fifo_rd_data = '0;
  logic fifo_empty = 1, fifo_full = 0;
  logic strb_a_o, strb_b_o, strb_oe, ack_o, bus_oe, fifo_push, fifo_pop;
  logic [DW-1:0] bus_d_o, fifo_wr_data;

  always #10 clk = ~clk;

  dual_style_port u_dual_style_port (
    .clk(clk), .rst_n(rst_n), .cfg_style_moto(cfg_style_moto), .cfg_periph(cfg_periph),
    .cfg_dir_rd(cfg_dir_rd), .cfg_req_pol(cfg_req_pol), .cfg_ack_pol(cfg_ack_pol),
    .strb_a_i(strb_a_i), .strb_b_i(strb_b_i), .strb_a_o(strb_a_o), .strb_b_o(strb_b_o),
    .strb_oe(strb_oe), .req_i(req_i), .ack_o(ack_o), .pclk_i(pclk_i), .bus_d_i(bus_d_i),
    .bus_d_o(bus_d_o), .bus_oe(bus_oe), .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_wr_data(fifo_wr_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: FIFO queue plus a per-clock expectation.
  logic [DW-1:0] q[$];
  logic [DW-1:0] pushed_log[$];
  int n_push = 0, n_pop = 0, n_ack = 0;
  bit ack_seen_prev = 0;

  logic [3:0] hc[3];          // recent control samples {a,b,req,pclk}
  logic [DW-1:0] hd[2];
  bit m_ack, e_push, e_pop, e_tick, e_rr;
  logic [DW-1:0] e_wdata, m_dout;

  initial begin
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        for (int i = 0; i < 3; i++) hc[i] = 4'b1100;
        hd[0] = '0; hd[1] = '0;
        m_ack = 0; e_push = 0; e_pop = 0; e_tick = 0; e_rr = 0; m_dout = '0;
        q.delete();
        #1 fifo_empty = 1; fifo_full = 0; fifo_rd_data = '0;
      end else begin
        bit a, ap, b, bp, r, c, cp, tick, rr, xfer, ev_push, ev_pop, oe, sa, sb;
        string tp, tq;
        if (e_pop) begin m_dout = q[0]; void'(q.pop_front()); end
        if (e_push) q.push_back(e_wdata);
        if (!cfg_periph) m_ack = 0;
        else if (e_tick) m_ack = !m_ack && e_rr;
        hc[2] = hc[1]; hc[1] = hc[0];
        hc[0] = {strb_a_i, strb_b_i, req_i, pclk_i};
        hd[1] = hd[0]; hd[0] = bus_d_i;
        #1;
        fifo_empty = (q.size() == 0);
        fifo_full  = (q.size() >= QMAX);
        fifo_rd_data = (q.size() > 0) ? q[0] : '0;
        a = hc[1][3]; ap = hc[2][3]; b = hc[1][2]; bp = hc[2][2];
        r = hc[1][1]; c = hc[1][0]; cp = hc[2][0];
        e_wdata = hd[1];
        tick = 0; rr = 0;
        if (cfg_periph) begin
          tick = c && !cp;
          rr = (r == cfg_req_pol) && (cfg_dir_rd ? !fifo_empty : !fifo_full);
          xfer = tick && !m_ack && rr;
          e_push = xfer && !cfg_dir_rd;
          e_pop  = xfer && cfg_dir_rd;
          oe = m_ack && cfg_dir_rd;
          tp = "R5"; tq = "R5";
        end else begin
          if (cfg_style_moto) begin
            ev_pop = ap && !a && b; ev_push = !ap && a && !b; oe = !a && b;
            tp = "R4"; tq = "R4";
          end else begin
            ev_pop = ap && !a; ev_push = !bp && b; oe = !a;
            tp = "R2"; tq = "R3";
          end
          e_push = ev_push && !fifo_full;
          e_pop  = ev_pop && !fifo_empty;
        end
        e_tick = tick; e_rr = rr;
        if (cfg_style_moto) begin sa = !m_ack; sb = cfg_dir_rd; end
        else begin sa = !(m_ack && cfg_dir_rd); sb = !(m_ack && !cfg_dir_rd); end
        #4;
        chk(fifo_push === e_push, {tp, " R7 push"}, fifo_push, e_push);
        chk(fifo_pop === e_pop, {tq, " R7 pop"}, fifo_pop, e_pop);
        if (e_push) chk(fifo_wr_data === e_wdata, {tp, " push data"}, fifo_wr_data, e_wdata);
        chk(bus_d_o === m_dout, "R3 bus data", bus_d_o, m_dout);
        chk(bus_oe === oe, "R10 bus_oe", bus_oe, oe);
        chk(ack_o === (m_ack ? cfg_ack_pol : !cfg_ack_pol), "R6 R8 ack_o", ack_o,
            m_ack ? cfg_ack_pol : !cfg_ack_pol);
        chk(strb_oe === cfg_periph, "R5 strb_oe", strb_oe, cfg_periph);
        if (cfg_periph) begin
          chk(strb_a_o === sa, "R9 strb_a_o", strb_a_o, sa);
          chk(strb_b_o === sb, "R9 strb_b_o", strb_b_o, sb);
        end
        if (fifo_push) begin n_push++; pushed_log.push_back(fifo_wr_data); end
        if (fifo_pop) n_pop++;
        if (m_ack && !ack_seen_prev) n_ack++;
        ack_seen_prev = m_ack;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic intel_write(input logic [DW-1:0] w);
    bus_d_i = w; idle(1);
    strb_b_i = 0; idle(3);
    strb_b_i = 1; idle(4);
  endtask

  task automatic intel_read();
    strb_a_i = 0; idle(5);
    strb_a_i = 1; idle(4);
  endtask

  task automatic moto_write(input logic [DW-1:0] w);
    strb_b_i = 0; bus_d_i = w; idle(1);
    strb_a_i = 0; idle(3);
    strb_a_i = 1; idle(4);
    strb_b_i = 1; idle(2);
  endtask

  task automatic moto_read();
    strb_b_i = 1; idle(1);
    strb_a_i = 0; idle(5);
    strb_a_i = 1; idle(4);
  endtask

  task automatic pclk_run(input int n, input logic [DW-1:0] base);
    for (int k = 0; k < n; k++) begin
      pclk_i = 0; bus_d_i = base + DW'(k); idle(3);
      pclk_i = 1; idle(3);
    end
    pclk_i = 0; idle(6);
  endtask

  initial begin : wdog
    for (int i = 0; i < WDOG; i++) begin
      @(posedge clk);
      if (done) disable wdog;
    end
    errors++;
    $display("FAIL watchdog expired: actual %0d cycles expected completion", WDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base_push, base_pop, base_ack;
    logic [DW-1:0] held;
    idle(4);
    rst_n = 1;
    idle(6);
    // R1: reset state
    chk(fifo_push === 0 && fifo_pop === 0, "R1 no transfer", {fifo_push, fifo_pop}, 0);
    chk(bus_oe === 0, "R1 bus_oe", bus_oe, 0);
    chk(strb_oe === 0, "R1 strb_oe", strb_oe, 0);
    chk(ack_o === 0, "R1 ack inactive", ack_o, 0);
    chk(bus_d_o === '0, "R1 bus_d_o", bus_d_o, 0);

    // R2: Intel writes
    intel_write(18'h1_2345); intel_write(18'h2_0A0A); intel_write(18'h3_FFFF);
    chk(n_push == 3, "R2 push count", n_push, 3);
    chk(pushed_log.size() == 3 && pushed_log[1] == 18'h2_0A0A, "R2 pushed word",
        pushed_log.size() > 1 ? pushed_log[1] : 0, 18'h2_0A0A);

    // R3: Intel reads
    intel_read();
    chk(bus_d_o === 18'h1_2345, "R3 first read", bus_d_o, 18'h1_2345);
    intel_read(); intel_read();
    chk(bus_d_o === 18'h3_FFFF, "R3 third read", bus_d_o, 18'h3_FFFF);

    // R7: read on empty ignored
    base_pop = n_pop; held = bus_d_o;
    intel_read();
    chk(n_pop == base_pop, "R7 pop on empty", n_pop, base_pop);
    chk(bus_d_o === held, "R7 bus held on empty", bus_d_o, held);

    // R7: write on full ignored
    base_push = n_push;
    for (int i = 0; i < 5; i++) intel_write(18'h0_0100 + DW'(i));
    chk(n_push - base_push == 4, "R7 push on full", n_push - base_push, 4);

    // R4: Motorola style
    cfg_style_moto = 1; idle(4);
    base_pop = n_pop;
    for (int i = 0; i < 4; i++) moto_read();
    chk(n_pop - base_pop == 4, "R4 moto pops", n_pop - base_pop, 4);
    chk(bus_d_o === 18'h0_0103, "R4 moto last read", bus_d_o, 18'h0_0103);
    base_push = n_push;
    moto_write(18'h2_5A5A); moto_write(18'h1_0F0F);
    chk(n_push - base_push == 2, "R4 moto pushes", n_push - base_push, 2);
    chk(pushed_log[$] == 18'h1_0F0F, "R4 moto push data", pushed_log[$], 18'h1_0F0F);

    // R5 R6 R9: peripheral write, active-low request and acknowledge, Motorola strobes
    cfg_periph = 1; cfg_dir_rd = 0; cfg_req_pol = 0; cfg_ack_pol = 0; req_i = 1; idle(4);
    chk(strb_oe === 1, "R5 strb_oe periph", strb_oe, 1);
    chk(ack_o === 1, "R8 ack idle high", ack_o, 1);
    base_ack = n_ack;
    pclk_run(4, 18'h0_0200);
    chk(n_ack == base_ack, "R8 inactive request", n_ack, base_ack);
    req_i = 0;
    base_push = n_push;
    pclk_run(8, 18'h0_0300);
    chk(n_push - base_push == 2, "R7 periph full withholds", n_push - base_push, 2);
    req_i = 1; idle(4);

    // peripheral read, active-high polarities, Intel strobes
    cfg_style_moto = 0; cfg_dir_rd = 1; cfg_req_pol = 1; cfg_ack_pol = 1; idle(4);
    base_pop = n_pop; base_ack = n_ack;
    pclk_run(12, 18'h0);
    chk(n_pop - base_pop == 4, "R5 periph pops", n_pop - base_pop, 4);
    chk(n_ack - base_ack == 4, "R6 one ack per word", n_ack - base_ack, 4);
    req_i = 0; idle(4);

    // back to Intel processor role
    cfg_periph = 0; cfg_dir_rd = 0; idle(4);
    chk(strb_oe === 0 && ack_o === 0, "R1 return to processor", {strb_oe, ack_o}, 0);
    intel_write(18'h3_1111); intel_read();
    chk(bus_d_o === 18'h3_1111, "R3 after mode return", bus_d_o, 18'h3_1111);

    idle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule